// File: doc/BRIEF.md
# Headphone Output Soft-Ramp Sequencer

This block sets the gain level of a headphone output stage so that the level changes in small steps and the output does not pop. A standby input selects the direction. When standby is low the block raises the level one step per tick until it reaches the top level. When standby is high it lowers the level one step per tick until it reaches zero. Ticks come from a free-running divider of the block clock.

Completion is reported through two sticky flags in an 8-bit flag register. The up-done flag is set when an upward ramp reaches the top level. The down-done flag is set when a downward ramp reaches zero. Software clears the relevant flag, changes standby, and then polls until hardware sets the flag again. Clearing uses write-zero semantics, so a software write cannot wipe out a flag it did not mean to touch.

Top module: `hp_ramp_seq`

## Requirements
- R1: A synchronous reset, in any state, sets the level to 0, clears both flags and restarts the tick divider.
- R2: While standby is low, the level rises by exactly one at each tick until it reaches LEVELS-1 (31 by default), and then it holds.
- R3: While standby is high, the level falls by exactly one at each tick until it reaches 0, and then it holds.
- R4: A tick occurs on every TICK_CYCLES-th clock edge after reset is released (every 64th by default). The level changes on no other edge. Standby is sampled on the tick edge itself.
- R5: The up-done flag (bit 3) is set on the edge where the level steps into LEVELS-1. The down-done flag (bit 2) is set on the edge where the level steps into 0. Both flags stay set until they are cleared.
- R6: A flag write that has a 0 in bit 3 or bit 2 clears that flag on the same edge.
- R7: A 1 written to a flag bit leaves that flag unchanged. Bits 7:4 and 1:0 of the flag register always read 0, and writes to them have no effect.
- R8: If a flag is set by hardware and cleared by a write on the same edge, the flag ends up set.
- R9: If standby changes partway through a ramp, the level reverses from its current value. Only the flag of the ramp that actually reaches its end is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| stby_i | input | 1 | Output stage standby: 1 ramps the level down, 0 ramps it up |
| flag_we_i | input | 1 | Write strobe for the flag register |
| flag_wdata_i | input | 8 | Write data: a 0 in bit 3 or bit 2 clears that flag |
| flag_rdata_o | output | 8 | Flag register: bit 3 up-done, bit 2 down-done, all other bits 0 |
| level_o | output | $clog2(LEVELS) | Current ramp level, from 0 to LEVELS-1 |

## Verification
The hardest case to reach is the collision in R8. It needs a write that clears up-done to land on exactly the tick edge where the level steps from 30 to 31. Only the divider phase decides that edge.

The bench reaches it using its own behavioural model of the divider. It waits for the negative edge at which the model shows level 30 with the divider on its last count, and drives the clearing write there.

The mid-ramp reversal is reached by flipping standby once the level reads 10. The model, compared on every cycle, then confirms that the level turns around and that only down-done appears.

// File: rtl/hp_ramp_pkg.sv
package hp_ramp_pkg;
  // Flag register layout. The flags occupy adjacent bits, with down-done lowest.
  localparam int FLAG_REG_W  = 8;
  localparam int DN_DONE_BIT = 2;
  localparam int NUM_FLAGS   = 2;
  localparam int UP_DONE_BIT = DN_DONE_BIT + 1;

  // Index of each flag inside the internal flag vector.
  localparam int IDX_DN = 0;
  localparam int IDX_UP = 1;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/hp_ramp_tick.sv
module hp_ramp_tick #(
  parameter int TICK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  // Free-running divider; it wraps after TICK_CYCLES edges.
  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/hp_ramp_level.sv
module hp_ramp_level
  import hp_ramp_pkg::*;
#(
  parameter int LEVELS = 32,
  parameter int LVL_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             stby_i,
  output logic [LVL_W-1:0] level_o,
  output logic             up_done_o,
  output logic             dn_done_o
);
  localparam logic [LVL_W-1:0] TOP  = LVL_W'(LEVELS - 1);
  localparam logic [LVL_W-1:0] ONE  = LVL_W'(1);

  logic [LVL_W-1:0] level_q;
  step_e            step;

  // Choose the step direction on a tick. The level saturates at both ends.
  always_comb begin
    step = STEP_HOLD;
    if (tick_i) begin
      if (!stby_i && (level_q != TOP))     step = STEP_UP;
      else if (stby_i && (level_q != '0))  step = STEP_DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
    end else begin
      case (step)
        STEP_UP:   level_q <= level_q + ONE;
        STEP_DOWN: level_q <= level_q - ONE;
        default:   level_q <= level_q;
      endcase
    end
  end

  // Completion pulses are raised only by the step that lands on an end point.
  assign up_done_o = (step == STEP_UP)   && (level_q == TOP - ONE);
  assign dn_done_o = (step == STEP_DOWN) && (level_q == ONE);
  assign level_o   = level_q;
endmodule

// File: rtl/hp_ramp_flags.sv
module hp_ramp_flags
  import hp_ramp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_FLAGS-1:0]  set_i,
  input  logic                  we_i,
  input  logic [FLAG_REG_W-1:0] wdata_i,
  output logic [FLAG_REG_W-1:0] rdata_o
);
  logic [NUM_FLAGS-1:0] flag_vec;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    localparam int POS = DN_DONE_BIT + i;
    logic q;
    logic clr;

    assign clr = we_i && !wdata_i[POS];

    // A hardware set takes priority over a write-zero clear.
    always_ff @(posedge clk) begin
      if (rst)        q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr)   q <= 1'b0;
    end

    assign flag_vec[i] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_FLAGS; k++) rdata_o[DN_DONE_BIT + k] = flag_vec[k];
  end
endmodule

// File: rtl/hp_ramp_seq.sv
module hp_ramp_seq
  import hp_ramp_pkg::*;
#(
  parameter int LEVELS      = 32,
  parameter int TICK_CYCLES = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      stby_i,
  input  logic                      flag_we_i,
  input  logic [7:0]                flag_wdata_i,
  output logic [7:0]                flag_rdata_o,
  output logic [$clog2(LEVELS)-1:0] level_o
);
  localparam int LVL_W = $clog2(LEVELS);

  logic                 tick;
  logic                 up_done;
  logic                 dn_done;
  logic [NUM_FLAGS-1:0] set_vec;

  hp_ramp_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  hp_ramp_level #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_level (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .stby_i    (stby_i),
    .level_o   (level_o),
    .up_done_o (up_done),
    .dn_done_o (dn_done)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[IDX_UP] = up_done;
    set_vec[IDX_DN] = dn_done;
  end

  hp_ramp_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_vec),
    .we_i    (flag_we_i),
    .wdata_i (flag_wdata_i),
    .rdata_o (flag_rdata_o)
  );
endmodule

// File: rtl/hp_ramp_seq_chk.sv
module hp_ramp_seq_chk
  import hp_ramp_pkg::*;
#(
  parameter int LEVELS      = 32,
  parameter int TICK_CYCLES = 64
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      stby_i,
  input logic                      flag_we_i,
  input logic [7:0]                flag_wdata_i,
  input logic [7:0]                flag_rdata_o,
  input logic [$clog2(LEVELS)-1:0] level_o
);
  localparam int LVL_W = $clog2(LEVELS);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(LEVELS - 1);

  // The checker keeps its own phase counter for the tick window.
  int unsigned phase;
  always_ff @(posedge clk) begin
    if (rst)                            phase <= 0;
    else if (phase == TICK_CYCLES - 1)  phase <= 0;
    else                                phase <= phase + 1;
  end

  assert_step_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (level_o != $past(level_o))) |-> ($past(phase) == TICK_CYCLES - 1));

  assert_rise_when_awake_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (level_o > $past(level_o))) |-> !$past(stby_i));

  assert_fall_in_standby_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (level_o < $past(level_o))) |-> $past(stby_i));

  assert_up_flag_at_top_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_rdata_o[UP_DONE_BIT]) |-> (level_o == TOP));

  assert_dn_flag_at_floor_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_rdata_o[DN_DONE_BIT]) |-> (level_o == '0));

  assert_clear_in_standby_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && !flag_wdata_i[UP_DONE_BIT] && stby_i) |=> !flag_rdata_o[UP_DONE_BIT]);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_rdata_o[UP_DONE_BIT] && !(flag_we_i && !flag_wdata_i[UP_DONE_BIT]))
      |=> flag_rdata_o[UP_DONE_BIT]);
endmodule

bind hp_ramp_seq hp_ramp_seq_chk #(.LEVELS(LEVELS), .TICK_CYCLES(TICK_CYCLES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stby_i       (stby_i),
  .flag_we_i    (flag_we_i),
  .flag_wdata_i (flag_wdata_i),
  .flag_rdata_o (flag_rdata_o),
  .level_o      (level_o)
);

// File: tb/hp_ramp_seq_bench.sv
`timescale 1ns/1ps
module hp_ramp_seq_bench;
  localparam int LEVELS = 32;
  localparam int TICK   = 64;
  localparam int MAX    = LEVELS - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stby = 1'b1;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'hFF;
  logic [7:0] rdata;
  logic [4:0] level;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // Behavioural reference state.
  int m_cnt = 0;
  int m_lvl = 0;
  int m_up = 0;
  int m_dn = 0;
  int m_su, m_sd;
  bit live = 1'b0;

  always #2 clk = ~clk;

  hp_ramp_seq u_hp_ramp_seq (
    .clk          (clk),
    .rst          (rst),
    .stby_i       (stby),
    .flag_we_i    (we),
    .flag_wdata_i (wdata),
    .flag_rdata_o (rdata),
    .level_o      (level)
  );

  always @(posedge clk) begin
    live = 1'b1;
    if (rst) begin
      m_cnt = 0; m_lvl = 0; m_up = 0; m_dn = 0;
    end else begin
      m_su = 0; m_sd = 0;
      if (m_cnt == TICK - 1) begin
        m_cnt = 0;
        if (!stby) begin
          if (m_lvl < MAX) begin m_lvl = m_lvl + 1; m_su = (m_lvl == MAX); end
        end else begin
          if (m_lvl > 0) begin m_lvl = m_lvl - 1; m_sd = (m_lvl == 0); end
        end
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (we && !wdata[3]) m_up = 0;
      if (we && !wdata[2]) m_dn = 0;
      if (m_su != 0) m_up = 1;
      if (m_sd != 0) m_dn = 1;
    end
  end

  // Every cycle: compare the design against the model.
  always @(negedge clk) begin
    if (live) begin
      n_cmp++;
      if (int'(level) != m_lvl) begin
        n_bad++;
        $display("FAIL level (R2 R3 R4 R9) act=%0d exp=%0d", level, m_lvl);
      end
      n_cmp++;
      if (int'(rdata) != (m_up * 8 + m_dn * 4)) begin
        n_bad++;
        $display("FAIL flags (R5 R6 R7 R8) act=%0h exp=%0h", rdata, m_up * 8 + m_dn * 4);
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1;
    wdata = d;
    @(negedge clk);
    we = 1'b0;
    wdata = 8'hFF;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(level == 0, "R1 level after reset", level, 0);
    chk(rdata == 8'h00, "R1 flags after reset", rdata, 0);
    rst = 1'b0;

    // Ramp up from the floor.
    wr(8'h00);
    stby = 1'b0;
    while (!rdata[3]) @(negedge clk);
    chk(level == 5'(MAX), "R2 level at top on up-done", level, MAX);
    chk(rdata == 8'h08, "R5 only up-done set", rdata, 8);

    // Writes of one and to the unused bits.
    wr(8'hFF);
    chk(rdata == 8'h08, "R7 write ones keeps flag", rdata, 8);
    wr(8'hFB);
    chk(rdata == 8'h08, "R7 bit3 one keeps up-done", rdata, 8);
    wr(8'hF7);
    chk(rdata == 8'h00, "R6 bit3 zero clears up-done", rdata, 0);

    // Ramp down to the floor.
    stby = 1'b1;
    while (!rdata[2]) @(negedge clk);
    chk(level == 0, "R3 level at floor on down-done", level, 0);
    chk(rdata == 8'h04, "R5 only down-done set", rdata, 4);

    // Reversal partway through a ramp.
    wr(8'h00);
    chk(rdata == 8'h00, "R6 clear down-done", rdata, 0);
    stby = 1'b0;
    while (level != 5'd10) @(negedge clk);
    stby = 1'b1;
    while (!rdata[2]) @(negedge clk);
    chk(rdata == 8'h04, "R9 only completed ramp flagged", rdata, 4);
    chk(level == 0, "R9 reversed to floor", level, 0);

    // A hardware set and a clear on the same edge.
    stby = 1'b0;
    while (!(m_lvl == MAX - 1 && m_cnt == TICK - 1)) @(negedge clk);
    wr(8'h00);
    chk(rdata == 8'h08, "R8 set wins over same-edge clear", rdata, 8);
    chk(level == 5'(MAX), "R8 level reached top", level, MAX);

    // Reset from an active state.
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(level == 0, "R1 level after late reset", level, 0);
    chk(rdata == 8'h00, "R1 flags after late reset", rdata, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule